// File: doc/BRIEF.md
# Triangular-Window Bitstream Decimator

This block turns a one-bit delta-sigma stream into one signed multi-bit value for each conversion. A conversion lasts `CONV_LEN` modulator steps, and a step is taken on each cycle where the modulator strobe is high. Each step adds a weight to a signed running sum when the stream bit is 1, and subtracts that weight when the bit is 0. The weight climbs by one per step through the first half of the conversion and then falls by one per step until it reaches zero. The result is therefore a triangle-weighted average of the stream.

A one-cycle start pulse begins a conversion, and the sum is cleared at that moment. Two pulses mark the timing. `mid_mark` fires on the step that first reaches the peak weight, which is the instant the input is effectively sampled. `ready` fires when the last step has been taken, and `result` is updated at the same time. Start pulses that arrive while a conversion is running are dropped. The system around the block decides when to issue start pulses.

The control is a three-state machine. The states are IDLE, RISE and FALL, and the transitions are:

- GO takes IDLE to RISE when a start pulse arrives.
- PEAK takes RISE to FALL on the strobe of step `CONV_LEN/2-1`.
- DONE takes FALL to IDLE on the strobe of step `CONV_LEN-1`.

Top module: `tri_window_avg`

## Requirements
- R1: A start pulse seen in IDLE clears the sum. Every `mod_stb` cycle after the start cycle counts as one step. A strobe in the start cycle itself is not counted, and cycles without a strobe change nothing, whatever `mod_bit` is.
- R2: Step k, counted from 0, has weight k+1 for k < N/2 and weight N−k otherwise, where N is `CONV_LEN`. A bit value of 1 adds the weight and 0 subtracts it. `result` is a two's-complement value `ACC_W` bits wide. An all-ones stream gives N/2·(N/2+1), and an all-zeros stream gives the negative of that value.
- R3: `ready` is high for exactly one cycle. That cycle follows the clock edge that takes step N−1, and the new `result` is visible in the same cycle.
- R4: `mid_mark` is high for exactly one cycle. That cycle follows the edge that takes step N/2−1, which is the first step at the peak weight N/2.
- R5: A start pulse during RISE or FALL is ignored. This holds even in the cycle of the final strobe, and the running sum and step count are left untouched.
- R6: `result` holds its value between `ready` pulses, and strobes in IDLE do not disturb it.
- R7: A synchronous reset returns the block to IDLE with `result`, `ready` and `mid_mark` all at zero, even in the middle of a conversion.
- R8: A start pulse in the cycle where `ready` is high is accepted, so conversions can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator stream bit |
| mod_stb | input | 1 | Marks a cycle that carries a valid modulator bit |
| start | input | 1 | Begins a conversion when the block is idle |
| result | output | ACC_W | Signed weighted sum of the last completed conversion |
| ready | output | 1 | One-cycle pulse when a new result is available |
| mid_mark | output | 1 | One-cycle pulse at the peak-weight step |

## Verification
The ports expose most internal errors quickly. If the step counter has drifted, `mid_mark` or `ready` leaves the strobe on which it belongs, and the per-clock comparison catches this within the same conversion. An error in the weight or the sign shows up as a wrong `result` at the next `ready` and nowhere earlier, so the bench uses several bit patterns that weight the rising and falling halves differently. A state machine that wrongly accepts a start pulse mid-conversion restarts the sum, which delays `ready` past the expected cycle or changes its value.

// File: rtl/tri_avg_pkg.sv
package tri_avg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } tri_state_e;

endpackage

// File: rtl/tri_step_ctr.sv
module tri_step_ctr #(
    parameter int CONV_LEN = 16,
    parameter int STEP_W   = $clog2(CONV_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              adv,
    output logic [STEP_W-1:0] step,
    output logic              at_peak,
    output logic              at_last
);
    localparam logic [STEP_W-1:0] PEAK_IDX = STEP_W'(CONV_LEN / 2 - 1);
    localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(CONV_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            step <= '0;
        end else if (adv) begin
            step <= (step == LAST_IDX) ? '0 : step + 1'b1;
        end
    end

    assign at_peak = (step == PEAK_IDX);
    assign at_last = (step == LAST_IDX);
endmodule

// File: rtl/tri_weight_gen.sv
module tri_weight_gen #(
    parameter int CONV_LEN = 16,
    parameter int STEP_W   = $clog2(CONV_LEN),
    parameter int WEIGHT_W = $clog2(CONV_LEN / 2 + 1)
) (
    input  logic [STEP_W-1:0]   step,
    output logic [WEIGHT_W-1:0] weight
);
    localparam int HALF = CONV_LEN / 2;

    always_comb begin
        int s;
        s = int'(step);
        if (s < HALF) begin
            weight = WEIGHT_W'(s + 1);
        end else begin
            weight = WEIGHT_W'(CONV_LEN - s);
        end
    end
endmodule

// File: rtl/tri_accum.sv
module tri_accum #(
    parameter int WEIGHT_W = 4,
    parameter int ACC_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clr,
    input  logic                    add,
    input  logic                    bit_in,
    input  logic [WEIGHT_W-1:0]     weight,
    output logic signed [ACC_W-1:0] acc_next
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] w_ext;

    assign w_ext    = ACC_W'(weight);
    assign acc_next = bit_in ? (acc + w_ext) : (acc - w_ext);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (add) begin
            acc <= acc_next;
        end
    end
endmodule

// File: rtl/tri_window_avg.sv
module tri_window_avg
    import tri_avg_pkg::*;
#(
    parameter int CONV_LEN = 16,
    localparam int MAX_SUM  = (CONV_LEN / 2) * (CONV_LEN / 2 + 1),
    localparam int ACC_W    = $clog2(MAX_SUM + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mod_bit,
    input  logic                    mod_stb,
    input  logic                    start,
    output logic signed [ACC_W-1:0] result,
    output logic                    ready,
    output logic                    mid_mark
);
    localparam int STEP_W   = $clog2(CONV_LEN);
    localparam int WEIGHT_W = $clog2(CONV_LEN / 2 + 1);

    tri_state_e              state;
    tri_state_e              state_nx;
    logic                    take;
    logic                    clr;
    logic [STEP_W-1:0]       step;
    logic                    at_peak;
    logic                    at_last;
    logic [WEIGHT_W-1:0]     weight;
    logic signed [ACC_W-1:0] acc_next;
    logic                    peak_hit;
    logic                    last_hit;

    assign take     = mod_stb && (state != ST_IDLE);
    assign clr      = start && (state == ST_IDLE);
    assign peak_hit = take && (state == ST_RISE) && at_peak;
    assign last_hit = take && (state == ST_FALL) && at_last;

    tri_step_ctr #(.CONV_LEN(CONV_LEN), .STEP_W(STEP_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .adv     (take),
        .step    (step),
        .at_peak (at_peak),
        .at_last (at_last)
    );

    tri_weight_gen #(.CONV_LEN(CONV_LEN), .STEP_W(STEP_W), .WEIGHT_W(WEIGHT_W)) u_wgt (
        .step   (step),
        .weight (weight)
    );

    tri_accum #(.WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .add      (take),
        .bit_in   (mod_bit),
        .weight   (weight),
        .acc_next (acc_next)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions GO, PEAK, DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start)    state_nx = ST_RISE;
            ST_RISE: if (peak_hit) state_nx = ST_FALL;
            ST_FALL: if (last_hit) state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            result   <= '0;
            ready    <= 1'b0;
            mid_mark <= 1'b0;
        end else begin
            ready    <= last_hit;
            mid_mark <= peak_hit;
            if (last_hit) begin
                result <= acc_next;
            end
        end
    end
endmodule

// File: rtl/tri_avg_chk.sv
module tri_avg_chk
    import tri_avg_pkg::*;
#(
    parameter int CONV_LEN = 16,
    parameter int ACC_W    = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    start,
    input logic                    mod_stb,
    input logic signed [ACC_W-1:0] result,
    input logic                    ready,
    input logic                    mid_mark,
    input tri_state_e              state
);
    localparam int MAX_SUM = (CONV_LEN / 2) * (CONV_LEN / 2 + 1);

    AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        ready |-> $past(mod_stb)); // R3

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ready |=> !ready); // R3

    AST_MID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        mid_mark |-> ($past(mod_stb) && !ready)); // R4

    AST_MID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mid_mark |=> !mid_mark); // R4

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RISE && start && !mod_stb) |=> (state == ST_RISE)); // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ready |-> $stable(result)); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (int'(result) <= MAX_SUM) && (int'(result) >= -MAX_SUM)); // R2
endmodule

bind tri_window_avg tri_avg_chk #(.CONV_LEN(CONV_LEN), .ACC_W(ACC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .mod_stb  (mod_stb),
    .result   (result),
    .ready    (ready),
    .mid_mark (mid_mark),
    .state    (state)
);

// File: tb/sim_tri_window_avg.sv
module sim_tri_window_avg;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int MAXS       = (N / 2) * (N / 2 + 1);
    localparam int AW         = $clog2(MAXS + 1) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mod_bit = 1'b0;
    logic mod_stb = 1'b0;
    logic start = 1'b0;
    logic signed [AW-1:0] result;
    logic ready;
    logic mid_mark;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tri_window_avg #(.CONV_LEN(N)) u0 (
        .clk      (clk),
        .rst      (rst),
        .mod_bit  (mod_bit),
        .mod_stb  (mod_stb),
        .start    (start),
        .result   (result),
        .ready    (ready),
        .mid_mark (mid_mark)
    );

    // Behavioural reference model
    int m_busy = 0, m_k = 0, m_acc = 0, m_res = 0, m_ready = 0, m_mid = 0;
    bit armed = 0;

    always @(posedge clk) begin
        int w;
        m_ready = 0;
        m_mid   = 0;
        if (rst) begin
            m_busy = 0; m_k = 0; m_acc = 0; m_res = 0;
        end else if (m_busy == 0) begin
            if (start) begin
                m_busy = 1; m_k = 0; m_acc = 0;
            end
        end else if (mod_stb) begin
            w = (m_k < N / 2) ? m_k + 1 : N - m_k;
            m_acc = mod_bit ? m_acc + w : m_acc - w;
            if (m_k == N / 2 - 1) m_mid = 1;
            if (m_k == N - 1) begin
                m_res = m_acc; m_ready = 1; m_busy = 0;
            end
            m_k = m_k + 1;
        end
        armed = 1;
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            check("R2", "result(model)", int'(result), m_res);
            check("R3", "ready(model)", int'(ready), m_ready);
            check("R4", "mid_mark(model)", int'(mid_mark), m_mid);
        end
    end

    task automatic drive(input logic b, input logic s, input logic st);
        mod_bit = b; mod_stb = s; start = st;
        @(negedge clk);
    endtask

    function automatic logic pat_bit(input int p, input int k);
        case (p)
            0: return 1'b1;
            1: return 1'b0;
            2: return (k % 2 == 0);
            3: return (k < N / 2);
            default: return (k % 3 == 0);
        endcase
    endfunction

    function automatic int exp_sum(input int p);
        int s = 0;
        for (int k = 0; k < N; k++) begin
            int w = (k < N / 2) ? k + 1 : N - k;
            s += pat_bit(p, k) ? w : -w;
        end
        return s;
    endfunction

    task automatic run_conv(input int p, input int gap, input bit inj_mid,
                            input bit inj_last, input bit stb_on_start, input string tag);
        drive(1'b1, stb_on_start, 1'b1);
        for (int k = 0; k < N; k++) begin
            repeat (gap) drive(1'($urandom % 2), 1'b0, 1'b0);
            drive(pat_bit(p, k), 1'b1, (inj_mid && k == 3) || (inj_last && k == N - 1));
            if (k == N / 2 - 1) check("R4", "mid_mark at peak", int'(mid_mark), 1);
        end
        check("R3", "ready after last step", int'(ready), 1);
        check(tag, "result value", int'(result), exp_sum(p));
    endtask

    initial begin
        int held;
        repeat (3) drive(1'b0, 1'b0, 1'b0);
        check("R7", "reset result", int'(result), 0);
        check("R7", "reset ready", int'(ready), 0);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0);
        check("R7", "idle mid_mark", int'(mid_mark), 0);

        run_conv(0, 0, 0, 0, 0, "R2");          // all ones: +MAXS
        check("R2", "all-ones peak sum", int'(result), MAXS);
        run_conv(1, 0, 0, 0, 0, "R2");          // R8 back to back, all zeros
        check("R2", "all-zeros sum", int'(result), -MAXS);
        run_conv(4, 2, 0, 0, 1, "R1");          // sparse strobes, start-cycle strobe
        run_conv(2, 1, 1, 0, 0, "R5");          // start injected mid-run
        run_conv(3, 0, 0, 1, 0, "R5");          // start on final strobe

        held = int'(result);
        for (int i = 0; i < 5; i++) begin
            drive(1'($urandom % 2), 1'b1, 1'b0);
            check("R6", "result held in idle", int'(result), held);
            check("R6", "no ready in idle", int'(ready), 0);
        end

        drive(1'b1, 1'b0, 1'b1);
        repeat (5) drive(1'b1, 1'b1, 1'b0);
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        check("R7", "result after mid-run reset", int'(result), 0);
        repeat (N + 2) drive(1'b1, 1'b1, 1'b0);
        check("R7", "idle after reset", int'(ready), 0);

        run_conv(4, 0, 0, 0, 0, "R8");
        drive(1'b0, 1'b0, 1'b0);
        check("R3", "ready one cycle", int'(ready), 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule